// File: doc/BRIEF.md
# PHY Configuration Packet Receive Handler

This block sits on the receive side of a serial-bus link layer. It takes in PHY packets as a stream of 32-bit quadlets. Each packet is two quadlets long, and the first one is marked by a start flag. The block checks that the second quadlet is the bitwise complement of the first. If a valid configuration packet arrives, the block applies two updates to node-local state: the force-root flag and the gap-count value.

The gap count takes effect as soon as the packet arrives. It stays in place through one bus reset. On the second bus reset after the most recent packet that carried a gap value, it goes back to 63.

When the forwarding enable bit from the control register is set, the block also copies every PHY packet into a general receive FIFO. It does this whether or not the packet is well formed, and it raises one header-error interrupt pulse per packet. The block does not hold the FIFO storage and does not take part in tree identification.

Top module: `phycfg_rx_handler`

## Requirements
- R1: After the synchronous active-low reset, gap_count is 63, force_root is 0, and fifo_wr_en and hdr_irq are both 0.
- R2: The first quadlet uses this layout: [31:30] identifier, where 00 marks a configuration packet; [29:24] target root ID; [23] root bit; [22] gap bit; [21:16] new gap value; [15:0] don't-care. A packet changes node state only if its second quadlet is the exact bitwise inverse of the first. If it is not, gap_count and force_root stay unchanged.
- R3: In an accepted packet with the root bit set, force_root becomes 1 if the target root ID equals local_phy_id, and 0 otherwise. The new value is visible on the cycle after the second quadlet is sampled.
- R4: In an accepted packet with the root bit clear, the target root ID is ignored and force_root keeps its value.
- R5: In an accepted packet with the gap bit set, gap_count takes the new gap value on the cycle after the second quadlet is sampled.
- R6: No state changes for a packet whose root and gap bits are both 0, or whose identifier is not 00.
- R7: gap_count keeps its value through the first bus_reset pulse after an accepted gap update and becomes 63 on the second. A new accepted gap update restarts this count.
- R8: When phy_pkt_fwd_en is 1 at the first quadlet, both quadlets are written in arrival order on fifo_wr_en/fifo_wr_data. Each write appears one cycle after its quadlet is sampled. Malformed packets are forwarded as well. When the enable is 0, nothing is written.
- R9: hdr_irq pulses high for exactly one cycle per forwarded packet, in the same cycle as the packet's second write. It never pulses for a packet that is not forwarded.
- R10: If an accepted gap update and a bus_reset pulse are sampled in the same cycle, the update wins, and the reset does not count towards reverting it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quad_valid | input | 1 | A quadlet is present on quad_data |
| quad_sop | input | 1 | Marks the first quadlet of a PHY packet |
| quad_data | input | 32 | Received quadlet |
| local_phy_id | input | 6 | Physical ID of this node |
| bus_reset | input | 1 | One-cycle pulse per bus reset |
| phy_pkt_fwd_en | input | 1 | Control-register bit that enables copying PHY packets to the FIFO |
| force_root | output | 1 | Force-root flag for the next tree identification |
| gap_count | output | 6 | Current gap count |
| fifo_wr_en | output | 1 | Write strobe to the general receive FIFO |
| fifo_wr_data | output | 32 | Quadlet written to the FIFO |
| hdr_irq | output | 1 | One-cycle header-error interrupt per forwarded packet |

## Verification
The decoder is tested with packets whose target ID matches the local ID and with packets whose target ID differs. It is also tested with every combination of the root and gap bits, with a non-configuration identifier, and with a corrupted inverse quadlet. These cases separate the effect of the root bit from that of the gap bit, and they separate the complement check from field decoding.

The gap-count lifetime is tested with sequences of zero, one, two and three bus resets after an update. A further case presents an update in the same cycle as a bus reset, which tests the priority between the update and the reset counter.

Forwarding is tested with the enable on and off, using both well-formed and malformed packets. This checks that the interrupt depends only on the enable and not on whether the packet is valid.

// File: rtl/phycfg_pkg.sv
// Package: shared field layout and constants for the PHY configuration
// packet receive handler. Assumes quadlets are 32 bits, with bit 31 sent first.
package phycfg_pkg;
    parameter int QUAD_W = 32;
    parameter int ID_W   = 6;
    parameter int GAP_W  = 6;
    localparam logic [GAP_W-1:0] GAP_DEFAULT = GAP_W'(63);
    localparam logic [1:0]       CFG_IDENT   = 2'b00;

    // First-quadlet layout, most significant field first
    typedef struct packed {
        logic [1:0]      ident;
        logic [ID_W-1:0] root_id;
        logic            root_bit;
        logic            gap_bit;
        logic [GAP_W-1:0] gap_val;
        logic [QUAD_W-2-ID_W-2-GAP_W-1:0] spare;
    } cfg_head_t;
endpackage

// File: rtl/phycfg_collector.sv
// Module: pairs the two quadlets of each PHY packet.
// Holds the first quadlet. When the next non-start quadlet arrives, it asserts
// pkt_done combinationally, for one cycle, with both quadlets presented.
// Assumes a start-flagged quadlet always begins a new packet, so a second
// start simply restarts pairing. A stray non-start quadlet with no packet
// open is dropped.
module phycfg_collector
    import phycfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quad_valid,
    input  logic              quad_sop,
    input  logic [QUAD_W-1:0] quad_data,
    output logic              pkt_done,
    output logic [QUAD_W-1:0] pkt_head,
    output logic [QUAD_W-1:0] pkt_check
);
    logic              open_q;
    logic [QUAD_W-1:0] head_q;

    // Capture the first quadlet and track whether a packet is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            head_q <= '0;
        end else if (quad_valid && quad_sop) begin
            open_q <= 1'b1;
            head_q <= quad_data;
        end else if (quad_valid && open_q) begin
            open_q <= 1'b0;
        end
    end

    // Present the completed pair
    always_comb begin
        pkt_done  = quad_valid && !quad_sop && open_q;
        pkt_head  = head_q;
        pkt_check = quad_data;
    end

    // A completed packet always closes the open slot (R8)
    assert_pair_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !open_q);
endmodule

// File: rtl/phycfg_forwarder.sv
// Module: copies PHY packets to the general receive FIFO and raises the
// header-error interrupt. The enable is sampled at the first quadlet,
// so each packet is forwarded either whole or not at all. Every output
// is registered, one cycle after the quadlet it carries.
module phycfg_forwarder
    import phycfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quad_valid,
    input  logic              quad_sop,
    input  logic [QUAD_W-1:0] quad_data,
    input  logic              pkt_done,
    input  logic              fwd_en,
    output logic              fifo_wr_en,
    output logic [QUAD_W-1:0] fifo_wr_data,
    output logic              hdr_irq
);
    logic armed_q;
    logic take_head;
    logic take_tail;

    // Decide which quadlets are written this cycle
    always_comb begin
        take_head = quad_valid && quad_sop && fwd_en;
        take_tail = pkt_done && armed_q;
    end

    // Latch the per-packet forwarding decision
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed_q <= 1'b0;
        else if (quad_valid && quad_sop) armed_q <= fwd_en;
        else if (pkt_done)             armed_q <= 1'b0;
    end

    // Register the FIFO write and the interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr_en   <= 1'b0;
            fifo_wr_data <= '0;
            hdr_irq      <= 1'b0;
        end else begin
            fifo_wr_en   <= take_head || take_tail;
            fifo_wr_data <= quad_data;
            hdr_irq      <= take_tail;
        end
    end

    // Interrupt only accompanies the closing write of a packet (R9)
    assert_irq_with_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_irq |-> fifo_wr_en);
    // Interrupt is a single-cycle pulse (R9)
    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_irq |=> !hdr_irq);
    // No write follows a cycle with no quadlet (R8)
    assert_write_needs_quad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !quad_valid |=> !fifo_wr_en);
endmodule

// File: rtl/phycfg_node_state.sv
// Module: decodes a completed packet and owns the force-root flag and the
// gap count. The gap count has a two-state reset tracker that records
// whether a bus reset has happened since the last gap update. An update
// sampled in the same cycle as a bus reset takes priority.
module phycfg_node_state
    import phycfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_done,
    input  logic [QUAD_W-1:0] pkt_head,
    input  logic [QUAD_W-1:0] pkt_check,
    input  logic [ID_W-1:0]   local_id,
    input  logic              bus_reset,
    output logic              force_root,
    output logic [GAP_W-1:0]  gap_count
);
    cfg_head_t head;
    logic      well_formed;
    logic      upd_root;
    logic      upd_gap;
    logic      reset_seen_q;

    // Decode the first quadlet and qualify the update strobes
    always_comb begin
        head        = cfg_head_t'(pkt_head);
        well_formed = pkt_done && (pkt_check == ~pkt_head) && (head.ident == CFG_IDENT);
        upd_root    = well_formed && head.root_bit;
        upd_gap     = well_formed && head.gap_bit;
    end

    // Force-root: set on the addressed node, cleared on all others
    always_ff @(posedge clk) begin
        if (!rst_n)        force_root <= 1'b0;
        else if (upd_root) force_root <= (head.root_id == local_id);
    end

    // Gap count with a one-reset survival window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_count    <= GAP_DEFAULT;
            reset_seen_q <= 1'b1;
        end else if (upd_gap) begin
            gap_count    <= head.gap_val;
            reset_seen_q <= 1'b0;
        end else if (bus_reset) begin
            if (reset_seen_q) gap_count <= GAP_DEFAULT;
            reset_seen_q <= 1'b1;
        end
    end

    // Force-root moves only after a root update (R3, R4)
    assert_root_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(force_root) |-> $past(upd_root));
    // Gap count moves only on an update or a bus reset (R6)
    assert_gap_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gap_count) |-> $past(upd_gap || bus_reset));
    // Corrupted complement leaves node state alone (R2)
    assert_bad_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_check != ~pkt_head && !bus_reset) |=>
            ($stable(gap_count) && $stable(force_root)));
    // Second reset without update restores the default (R7)
    assert_revert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && reset_seen_q && !upd_gap) |=> gap_count == GAP_DEFAULT);
    // Update beats a simultaneous reset (R10)
    assert_update_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_gap |=> (gap_count == $past(head.gap_val)));
endmodule

// File: rtl/phycfg_rx_handler.sv
// Module: top of the PHY configuration packet receive handler.
// It ties together the quadlet pairing stage, the node-state decoder and the
// FIFO forwarder. It assumes a single clock domain and that bus_reset is a
// one-cycle pulse.
module phycfg_rx_handler
    import phycfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quad_valid,
    input  logic              quad_sop,
    input  logic [QUAD_W-1:0] quad_data,
    input  logic [ID_W-1:0]   local_phy_id,
    input  logic              bus_reset,
    input  logic              phy_pkt_fwd_en,
    output logic              force_root,
    output logic [GAP_W-1:0]  gap_count,
    output logic              fifo_wr_en,
    output logic [QUAD_W-1:0] fifo_wr_data,
    output logic              hdr_irq
);
    logic              pkt_done;
    logic [QUAD_W-1:0] pkt_head;
    logic [QUAD_W-1:0] pkt_check;

    phycfg_collector u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .quad_valid(quad_valid),
        .quad_sop  (quad_sop),
        .quad_data (quad_data),
        .pkt_done  (pkt_done),
        .pkt_head  (pkt_head),
        .pkt_check (pkt_check)
    );

    phycfg_node_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_done  (pkt_done),
        .pkt_head  (pkt_head),
        .pkt_check (pkt_check),
        .local_id  (local_phy_id),
        .bus_reset (bus_reset),
        .force_root(force_root),
        .gap_count (gap_count)
    );

    phycfg_forwarder u_fwd (
        .clk         (clk),
        .rst_n       (rst_n),
        .quad_valid  (quad_valid),
        .quad_sop    (quad_sop),
        .quad_data   (quad_data),
        .pkt_done    (pkt_done),
        .fwd_en      (phy_pkt_fwd_en),
        .fifo_wr_en  (fifo_wr_en),
        .fifo_wr_data(fifo_wr_data),
        .hdr_irq     (hdr_irq)
    );

    // Quiet outputs while in reset (R1)
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!fifo_wr_en && !hdr_irq && !force_root && gap_count == GAP_W'(63)));
endmodule

// File: tb/phycfg_rx_handler_test.sv
// Directed bench for the PHY configuration packet receive handler.
// Inputs change on the falling edge and outputs are read on the falling edge.
module phycfg_rx_handler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        quad_valid = 1'b0;
    logic        quad_sop = 1'b0;
    logic [31:0] quad_data = '0;
    logic [5:0]  local_phy_id = 6'd5;
    logic        bus_reset = 1'b0;
    logic        phy_pkt_fwd_en = 1'b0;
    logic        force_root;
    logic [5:0]  gap_count;
    logic        fifo_wr_en;
    logic [31:0] fifo_wr_data;
    logic        hdr_irq;

    int tests_run = 0;
    int tests_failed = 0;
    int wr_count = 0;
    int irq_count = 0;
    logic [31:0] wr_log [0:15];

    always #4 clk = ~clk;

    phycfg_rx_handler uut (
        .clk(clk), .rst_n(rst_n), .quad_valid(quad_valid), .quad_sop(quad_sop),
        .quad_data(quad_data), .local_phy_id(local_phy_id), .bus_reset(bus_reset),
        .phy_pkt_fwd_en(phy_pkt_fwd_en), .force_root(force_root), .gap_count(gap_count),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .hdr_irq(hdr_irq)
    );

    // Record FIFO writes and interrupts away from the active edge
    always @(negedge clk) begin
        if (rst_n && fifo_wr_en) begin
            wr_log[wr_count[3:0]] = fifo_wr_data;
            wr_count = wr_count + 1;
        end
        if (rst_n && hdr_irq) irq_count = irq_count + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] head(input logic [1:0] id, input logic [5:0] root,
                                         input logic r, input logic t, input logic [5:0] gap);
        return {id, root, r, t, gap, 16'hA5C3};
    endfunction

    // Send one packet; optionally pulse bus_reset with the second quadlet
    task automatic send_pkt(input logic [31:0] q0, input logic [31:0] q1,
                            input logic en, input logic br_with_tail);
        @(negedge clk);
        quad_valid = 1'b1; quad_sop = 1'b1; quad_data = q0; phy_pkt_fwd_en = en;
        @(negedge clk);
        quad_sop = 1'b0; quad_data = q1; bus_reset = br_with_tail;
        @(negedge clk);
        quad_valid = 1'b0; quad_data = '0; bus_reset = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R1", "gap_count", gap_count, 63);
        check("R1", "force_root", force_root, 0);
        check("R1", "fifo_wr_en", fifo_wr_en, 0);
        check("R1", "hdr_irq", hdr_irq, 0);
    endtask

    task automatic t_root_and_gap();
        logic [31:0] q;
        int w0;
        int i0;
        w0 = wr_count; i0 = irq_count;
        q = head(2'b00, 6'd0, 1'b0, 1'b1, 6'd10);
        send_pkt(q, ~q, 1'b0, 1'b0);
        check("R5", "gap after T packet", gap_count, 10);
        check("R8", "no writes when disabled", wr_count - w0, 0);
        check("R9", "no irq when disabled", irq_count - i0, 0);
        q = head(2'b00, 6'd5, 1'b1, 1'b0, 6'd0);
        send_pkt(q, ~q, 1'b0, 1'b0);
        check("R3", "force_root on own id", force_root, 1);
        check("R5", "gap untouched by R-only", gap_count, 10);
        q = head(2'b00, 6'd9, 1'b0, 1'b1, 6'd20);
        send_pkt(q, ~q, 1'b0, 1'b0);
        check("R4", "force_root kept when R=0", force_root, 1);
        check("R5", "gap after second T", gap_count, 20);
        q = head(2'b00, 6'd9, 1'b1, 1'b0, 6'd0);
        send_pkt(q, ~q, 1'b0, 1'b0);
        check("R3", "force_root cleared on other id", force_root, 0);
    endtask

    task automatic t_rejects();
        logic [31:0] q;
        int w0;
        int i0;
        w0 = wr_count; i0 = irq_count;
        q = head(2'b00, 6'd5, 1'b1, 1'b1, 6'd7);
        send_pkt(q, ~q ^ 32'h0000_0100, 1'b1, 1'b0);
        check("R2", "bad inverse keeps force_root", force_root, 0);
        check("R2", "bad inverse keeps gap", gap_count, 20);
        check("R8", "bad packet still written", wr_count - w0, 2);
        check("R9", "bad packet still interrupts", irq_count - i0, 1);
        q = head(2'b00, 6'd5, 1'b0, 1'b0, 6'd5);
        send_pkt(q, ~q, 1'b0, 1'b0);
        check("R6", "extended packet keeps gap", gap_count, 20);
        check("R6", "extended packet keeps root", force_root, 0);
        q = head(2'b01, 6'd5, 1'b1, 1'b1, 6'd3);
        send_pkt(q, ~q, 1'b0, 1'b0);
        check("R6", "foreign identifier keeps gap", gap_count, 20);
        check("R6", "foreign identifier keeps root", force_root, 0);
    endtask

    task automatic t_forward_order();
        logic [31:0] q;
        int w0;
        int i0;
        w0 = wr_count; i0 = irq_count;
        q = head(2'b00, 6'd2, 1'b0, 1'b1, 6'd20);
        send_pkt(q, ~q, 1'b1, 1'b0);
        check("R8", "two writes", wr_count - w0, 2);
        check("R8", "first write is head", int'(wr_log[w0[3:0]] == q), 1);
        check("R8", "second write is inverse", int'(wr_log[(w0 + 1) % 16] == ~q), 1);
        check("R9", "one irq per packet", irq_count - i0, 1);
    endtask

    task automatic t_gap_lifetime();
        logic [31:0] q;
        pulse_bus_reset();
        check("R7", "gap survives first reset", gap_count, 20);
        pulse_bus_reset();
        check("R7", "gap reverts on second reset", gap_count, 63);
        pulse_bus_reset();
        check("R7", "stays default on third reset", gap_count, 63);
        q = head(2'b00, 6'd0, 1'b0, 1'b1, 6'd12);
        send_pkt(q, ~q, 1'b0, 1'b0);
        pulse_bus_reset();
        q = head(2'b00, 6'd0, 1'b0, 1'b1, 6'd30);
        send_pkt(q, ~q, 1'b0, 1'b0);
        pulse_bus_reset();
        check("R7", "new packet restarts count", gap_count, 30);
        pulse_bus_reset();
        check("R7", "reverts after restart", gap_count, 63);
    endtask

    task automatic t_same_cycle();
        logic [31:0] q;
        q = head(2'b00, 6'd0, 1'b0, 1'b1, 6'd11);
        send_pkt(q, ~q, 1'b0, 1'b0);
        pulse_bus_reset();
        q = head(2'b00, 6'd0, 1'b0, 1'b1, 6'd40);
        send_pkt(q, ~q, 1'b0, 1'b1);
        check("R10", "update wins over reset", gap_count, 40);
        pulse_bus_reset();
        check("R10", "coincident reset not counted", gap_count, 40);
        pulse_bus_reset();
        check("R10", "reverts on next second reset", gap_count, 63);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_root_and_gap();
        t_rejects();
        t_forward_order();
        t_gap_lifetime();
        t_same_cycle();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule